// File: doc/BRIEF.md
# Seconds Alarm Comparator

This block holds a programmable alarm time and watches a free-running seconds counter that lives elsewhere. The comparison happens only in the cycle where the counter signals that it is about to advance. If the stored alarm time equals the counter value at that step, a sticky alarm flag is raised. The flag stays raised until software writes the alarm register again. The write may carry the next alarm time. It may also carry a time already passed, such as zero, and then the flag never rises again as the counter moves forward.

The flag cannot be masked. A separate enable input gates only the interrupt line. A write and a matching step in the same cycle resolve in favour of the write. The equality compare is split into chunks of a parameterised width so that its logic depth can be tuned.

Top module: `sec_alarm_top`

## Requirements
- R1: After reset the stored alarm time is zero and flag_o and irq_o are low. A step with sec_i equal to zero then raises the flag.
- R2: When inc_i is high and sec_i equals the stored alarm time, flag_o is high from the next clock edge on. This includes the all-ones value.
- R3: While inc_i is low, the flag does not rise, even when sec_i equals the stored alarm time.
- R4: When inc_i is high and sec_i differs from the stored alarm time, the flag does not rise.
- R5: A cycle with wr_en_i high clears flag_o at the next edge, whatever the value written, including the value already stored.
- R6: When wr_en_i is high and a matching step occurs in the same cycle, flag_o is low after the edge.
- R7: Once raised, flag_o stays high through later steps, with or without a match, until the next write.
- R8: irq_o is high exactly when flag_o and irq_en_i are both high. irq_en_i has no effect on flag_o.
- R9: After the alarm time is written to a value below sec_i, steps with an increasing sec_i leave flag_o low.
- R10: A value written with wr_en_i is the value compared from the next cycle on. The old value no longer matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_i | input | SecW | Current seconds count |
| inc_i | input | 1 | One-cycle strobe: the seconds count advances this cycle |
| wr_en_i | input | 1 | Alarm register write strobe |
| wr_data_i | input | SecW | Alarm time to store |
| irq_en_i | input | 1 | Interrupt enable |
| flag_o | output | 1 | Sticky alarm flag |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The bench presents a matching seconds value without the step strobe. A design that compared continuously would raise the flag early. It collides a write with a matching step. A design that let the set win would leave the flag high with no way to see a clear. It rewrites the same alarm value while the flag is high and runs steps past a zero alarm, which catches a clear that depends on a changed value and an alarm that is not truly disarmed. It also toggles the enable around a raised flag, which shows an enable that wrongly masks the flag itself or fails to gate the line.

// File: rtl/sec_alarm_pkg.sv
package sec_alarm_pkg;
  parameter int unsigned SEC_W_DEF   = 32;
  parameter int unsigned CHUNK_W_DEF = 8;

  typedef enum logic [1:0] {
    FLG_HOLD = 2'd0,
    FLG_SET  = 2'd1,
    FLG_CLR  = 2'd2
  } flag_act_e;
endpackage

// File: rtl/sec_alarm_reg.sv
module sec_alarm_reg #(
  parameter int unsigned SecW = sec_alarm_pkg::SEC_W_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [SecW-1:0] wr_data_i,
  output logic [SecW-1:0] alarm_o
);
  logic [SecW-1:0] alarm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      alarm_q <= '0;
    else if (wr_en_i) alarm_q <= wr_data_i;
  end

  assign alarm_o = alarm_q;

  assert_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> alarm_o == $past(wr_data_i));
  assert_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(alarm_o));
endmodule

// File: rtl/sec_alarm_match.sv
module sec_alarm_match #(
  parameter int unsigned SecW   = sec_alarm_pkg::SEC_W_DEF,
  parameter int unsigned ChunkW = sec_alarm_pkg::CHUNK_W_DEF
) (
  input  logic            inc_i,
  input  logic [SecW-1:0] sec_i,
  input  logic [SecW-1:0] alarm_i,
  output logic            hit_o
);
  localparam int unsigned NumChunks = (SecW + ChunkW - 1) / ChunkW;
  localparam int unsigned PadW      = NumChunks * ChunkW;

  logic [PadW-1:0]      sec_pad, alm_pad;
  logic [NumChunks-1:0] chunk_eq;

  assign sec_pad = PadW'(sec_i);
  assign alm_pad = PadW'(alarm_i);

  // chunked equality keeps each reduction shallow
  for (genvar c = 0; c < NumChunks; c++) begin : g_chunk
    assign chunk_eq[c] = (sec_pad[c*ChunkW +: ChunkW] == alm_pad[c*ChunkW +: ChunkW]);
  end

  // compare only at the step
  assign hit_o = inc_i & (&chunk_eq);
endmodule

// File: rtl/sec_alarm_flag.sv
module sec_alarm_flag
  import sec_alarm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  flag_act_e act;
  logic      flag_q;

  // write beats set
  always_comb begin
    if (clr_i)      act = FLG_CLR;
    else if (set_i) act = FLG_SET;
    else            act = FLG_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else begin
      unique case (act)
        FLG_SET:  flag_q <= 1'b1;
        FLG_CLR:  flag_q <= 1'b0;
        default:  flag_q <= flag_q;
      endcase
    end
  end

  assign flag_o = flag_q;

  assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> flag_o);
  assert_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_o);
  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  assert_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !set_i) |=> !flag_o);
endmodule

// File: rtl/sec_alarm_top.sv
module sec_alarm_top #(
  parameter int unsigned SecW   = sec_alarm_pkg::SEC_W_DEF,
  parameter int unsigned ChunkW = sec_alarm_pkg::CHUNK_W_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SecW-1:0] sec_i,
  input  logic            inc_i,
  input  logic            wr_en_i,
  input  logic [SecW-1:0] wr_data_i,
  input  logic            irq_en_i,
  output logic            flag_o,
  output logic            irq_o
);
  logic [SecW-1:0] alarm_q;
  logic            hit;

  sec_alarm_reg #(.SecW(SecW)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .alarm_o   (alarm_q)
  );

  sec_alarm_match #(.SecW(SecW), .ChunkW(ChunkW)) u_match (
    .inc_i   (inc_i),
    .sec_i   (sec_i),
    .alarm_i (alarm_q),
    .hit_o   (hit)
  );

  sec_alarm_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hit),
    .clr_i  (wr_en_i),
    .flag_o (flag_o)
  );

  assign irq_o = flag_o & irq_en_i;

  assert_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> ($past(inc_i) && !$past(wr_en_i)
                       && ($past(sec_i) == $past(alarm_q))));
  assert_collide_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && inc_i && sec_i == alarm_q) |=> !flag_o);
  assert_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && irq_en_i));
endmodule

// File: tb/sec_alarm_top_tb.sv
module sec_alarm_top_tb_top;
  localparam int unsigned W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] sec = '0;
  logic         inc = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         irq_en = 1'b0;
  logic         flag, irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  sec_alarm_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sec_i(sec), .inc_i(inc),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .irq_en_i(irq_en),
    .flag_o(flag), .irq_o(irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, sample 1ns after posedge
  task automatic cyc(input logic [W-1:0] s, input logic i, input logic w, input logic [W-1:0] d);
    @(negedge clk);
    sec = s; inc = i; wr_en = w; wr_data = d;
    @(posedge clk); #1;
    inc = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr(input logic [W-1:0] d);
    cyc(sec, 1'b0, 1'b1, d);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 flag in reset", flag, 1'b0);
    chk("R1 irq in reset", irq, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    cyc(W'(0), 1'b1, 1'b0, '0);
    chk("R1 reset alarm is zero", flag, 1'b1);
    wr(W'(1000));
    chk("R5 write clears", flag, 1'b0);
  endtask

  task automatic t_compare;
    wr(W'(100));
    cyc(W'(99), 1'b1, 1'b0, '0);
    chk("R4 mismatch step", flag, 1'b0);
    cyc(W'(100), 1'b0, 1'b0, '0);
    chk("R3 match without step", flag, 1'b0);
    cyc(W'(100), 1'b1, 1'b0, '0);
    chk("R2 match step sets", flag, 1'b1);
    cyc(W'(101), 1'b1, 1'b0, '0);
    chk("R7 sticky over step", flag, 1'b1);
    cyc(W'(102), 1'b0, 1'b0, '0);
    chk("R7 sticky idle", flag, 1'b1);
  endtask

  task automatic t_irq;
    @(negedge clk); irq_en = 1'b0; #1;
    chk("R8 irq gated", irq, 1'b0);
    chk("R8 flag unmasked", flag, 1'b1);
    @(negedge clk); irq_en = 1'b1; #1;
    chk("R8 irq on", irq, 1'b1);
    wr(W'(100));
    chk("R5 same value clears", flag, 1'b0);
    chk("R8 irq follows flag", irq, 1'b0);
    @(negedge clk); irq_en = 1'b0;
  endtask

  task automatic t_collide;
    wr(W'(200));
    cyc(W'(200), 1'b1, 1'b1, W'(300));
    chk("R6 write wins", flag, 1'b0);
    cyc(W'(300), 1'b1, 1'b0, '0);
    chk("R10 new value compared", flag, 1'b1);
  endtask

  task automatic t_newval;
    wr(W'(40));
    wr(W'(50));
    cyc(W'(40), 1'b1, 1'b0, '0);
    chk("R10 old value dead", flag, 1'b0);
    cyc(W'(50), 1'b1, 1'b0, '0);
    chk("R10 written value live", flag, 1'b1);
  endtask

  task automatic t_disarm;
    logic seen = 1'b0;
    wr(W'(0));
    chk("R5 write zero clears", flag, 1'b0);
    for (int k = 500; k < 510; k++) begin
      cyc(W'(k), 1'b1, 1'b0, '0);
      seen = seen | flag;
    end
    chk("R9 past alarm stays low", seen, 1'b0);
  endtask

  task automatic t_wrap;
    wr('1);
    cyc('1 - W'(1), 1'b1, 1'b0, '0);
    chk("R4 near all-ones", flag, 1'b0);
    cyc('1, 1'b1, 1'b0, '0);
    chk("R2 all-ones match", flag, 1'b1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_compare();
    t_irq();
    t_collide();
    t_newval();
    t_disarm();
    t_wrap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule